// File: doc/BRIEF.md
# Register-Controlled Clock Divider

This block turns one of up to eight reference sources into a slower, registered clock signal. Every source is modelled as an enable strobe in the single system clock domain, and one strobe is one source cycle. A 32-bit control word, written through an address-less strobe-and-data port and read back on a separate bus, sets three things: the divide ratio, which source is used, and whether the output is stopped.

The parameter `NUM_SRC` selects the variant: one source, four sources or eight sources. The source-select field sits at a different bit position in the four-source and eight-source variants. The single-source variant has no select field and always uses source 0.

Settings are not applied the moment they are written. A new ratio, a new source or a stop request is taken only at the end of the current output period, when the output is low. This prevents truncated pulses and glitches. While the output is stopped, new settings are adopted at once.

Top module: `ckdiv_top`

## Requirements
- R1: A ratio code d in bits 5:0 divides the selected source by N = d+1, where N is from 1 to 64. For N of 2 or more, the output is high for floor(N/2) source cycles and low for the rest of each period.
- R2: With d = 0, the output is high in the system cycle after each strobe of the selected source and low otherwise.
- R3: While bit 8 is set, the output is held low. Clearing bit 8 starts the divider, and its first period begins with the high phase.
- R4: A write with bit 8 set and bits 5:0 equal to zero stores ratio code 63 (0x3F), so a stopped divider never holds a zero ratio code.
- R5: Reading back returns the stored value. Bits the variant does not use read as zero and ignore writes. The used bits are 5:0 and 8, plus 7:6 in the four-source variant, plus 14:12 in the eight-source variant.
- R6: After reset, the read value is 0x13F (stopped, ratio code 63, source 0) and the output is low.
- R7: The four-source variant takes its source index from bits 7:6. The eight-source variant takes it from bits 14:12. The single-source variant ignores those bits and uses source 0.
- R8: A ratio written while the divider runs takes effect only at the end of the current period. The pulse in progress keeps its full length.
- R9: A source change or a stop takes effect only at a period end, while the output is low. The output is low in the cycle the divider stops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Control word to write |
| rd_data_o | output | 32 | Stored control word |
| src_i | input | NUM_SRC | Source enable strobes, one per source |
| div_o | output | 1 | Divided clock output |

## Verification
Four properties are checked on every cycle:
- the active source only changes after a low output cycle;
- the active ratio only changes at a period end or while stopped;
- the output is low whenever the divider has just stopped or is stopped;
- the read value never shows a stop with a zero ratio and never has an unused bit set.

The bench scenarios cover what the properties cannot. They measure high time and period for several ratios and sources, including odd ratios and sources with slow strobes. They show that a pulse in progress keeps its full length when the ratio changes or a stop is requested. They also show that the single-source variant ignores the select bits, and they check the field positions of both multi-source variants.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;
  localparam int RATIO_W  = 6;
  localparam int STOP_BIT = 8;

  function automatic int sel_width(input int n);
    return (n == 8) ? 3 : (n == 4) ? 2 : 0;
  endfunction

  function automatic int sel_lsb(input int n);
    return (n == 8) ? 12 : (n == 4) ? 6 : 0;
  endfunction

  function automatic logic [31:0] used_mask(input int n);
    return 32'h0000_013F | (((32'd1 << sel_width(n)) - 32'd1) << sel_lsb(n));
  endfunction
endpackage

// File: rtl/ckdiv_regs.sv
module ckdiv_regs
  import ckdiv_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int SW      = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [31:0]         wr_data_i,
  output logic [31:0]         rd_data_o,
  output logic [RATIO_W-1:0]  ratio_o,
  output logic [SW-1:0]       sel_o,
  output logic                stop_o
);
  localparam int RSW = sel_width(NUM_SRC);
  localparam int LSB = sel_lsb(NUM_SRC);

  logic [SW-1:0] wr_sel;
  logic [31:0]   sel_field;
  logic          wr_stop;
  logic [RATIO_W-1:0] wr_ratio;

  generate
    if (RSW > 0) begin : g_sel
      assign wr_sel    = SW'(wr_data_i[LSB +: RSW]);
      assign sel_field = 32'(sel_o) << LSB;
    end else begin : g_nosel
      assign wr_sel    = '0;
      assign sel_field = '0;
    end
  endgenerate

  assign wr_stop  = wr_data_i[STOP_BIT];
  // zero code while stopped is replaced by all-ones
  assign wr_ratio = (wr_stop && wr_data_i[RATIO_W-1:0] == '0) ? '1 : wr_data_i[RATIO_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_o <= '1;
      stop_o  <= 1'b1;
      sel_o   <= '0;
    end else if (wr_en_i) begin
      ratio_o <= wr_ratio;
      stop_o  <= wr_stop;
      sel_o   <= wr_sel;
    end
  end

  assign rd_data_o = (32'(stop_o) << STOP_BIT) | 32'(ratio_o) | sel_field;
endmodule

// File: rtl/ckdiv_src_mux.sv
module ckdiv_src_mux #(
  parameter int NUM_SRC = 8,
  parameter int SW      = 3
) (
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [SW-1:0]      sel_i,
  output logic               tick_o
);
  logic [NUM_SRC-1:0] hit;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
      assign hit[i] = src_i[i] && (sel_i == SW'(i));
    end
  endgenerate

  assign tick_o = |hit;
endmodule

// File: rtl/ckdiv_core.sv
module ckdiv_core #(
  parameter int RW = 6,
  parameter int SW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [RW-1:0] cfg_ratio_i,
  input  logic [SW-1:0] cfg_sel_i,
  input  logic          cfg_run_i,
  output logic          div_o,
  output logic [RW-1:0] act_ratio_o,
  output logic [SW-1:0] act_sel_o,
  output logic          act_run_o,
  output logic [RW-1:0] cnt_o
);
  function automatic logic [RW:0] half_of(input logic [RW-1:0] d);
    return ({1'b0, d} + (RW+1)'(1)) >> 1;
  endfunction

  logic          period_end;
  logic [RW:0]   cnt_inc;

  assign period_end = (cnt_o == act_ratio_o);
  assign cnt_inc    = {1'b0, cnt_o} + (RW+1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_ratio_o <= '1;
      act_sel_o   <= '0;
      act_run_o   <= 1'b0;
      cnt_o       <= '1;
      div_o       <= 1'b0;
    end else if (!act_run_o) begin
      // stopped: adopt settings at once, park counter at period end
      act_ratio_o <= cfg_ratio_i;
      act_sel_o   <= cfg_sel_i;
      act_run_o   <= cfg_run_i;
      cnt_o       <= cfg_ratio_i;
      div_o       <= 1'b0;
    end else if (tick_i) begin
      if (period_end) begin
        act_ratio_o <= cfg_ratio_i;
        act_sel_o   <= cfg_sel_i;
        act_run_o   <= cfg_run_i;
        cnt_o       <= '0;
        div_o       <= cfg_run_i;
      end else begin
        cnt_o <= cnt_inc[RW-1:0];
        div_o <= (cnt_inc < half_of(act_ratio_o));
      end
    end else if (act_ratio_o == '0) begin
      div_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ckdiv_top.sv
module ckdiv_top
  import ckdiv_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [31:0]        wr_data_i,
  output logic [31:0]        rd_data_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               div_o
);
  localparam int SW = (sel_width(NUM_SRC) > 0) ? sel_width(NUM_SRC) : 1;

  logic [RATIO_W-1:0] cfg_ratio, act_ratio, cnt;
  logic [SW-1:0]      cfg_sel, act_sel;
  logic               cfg_stop, act_run, tick;

  ckdiv_regs #(.NUM_SRC(NUM_SRC), .SW(SW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .ratio_o   (cfg_ratio),
    .sel_o     (cfg_sel),
    .stop_o    (cfg_stop)
  );

  ckdiv_src_mux #(.NUM_SRC(NUM_SRC), .SW(SW)) u_mux (
    .src_i  (src_i),
    .sel_i  (act_sel),
    .tick_o (tick)
  );

  ckdiv_core #(.RW(RATIO_W), .SW(SW)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .cfg_ratio_i (cfg_ratio),
    .cfg_sel_i   (cfg_sel),
    .cfg_run_i   (!cfg_stop),
    .div_o       (div_o),
    .act_ratio_o (act_ratio),
    .act_sel_o   (act_sel),
    .act_run_o   (act_run),
    .cnt_o       (cnt)
  );
endmodule

// File: rtl/ckdiv_chk.sv
module ckdiv_chk
  import ckdiv_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int SW      = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               div_o,
  input logic [31:0]        rd_data_o,
  input logic [SW-1:0]      act_sel,
  input logic [RATIO_W-1:0] act_ratio,
  input logic [RATIO_W-1:0] cnt,
  input logic               act_run
);
  localparam logic [31:0] MASK = used_mask(NUM_SRC);

  p_sel_when_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_sel != $past(act_sel)) |-> !$past(div_o));

  p_stop_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(act_run) |-> !div_o);

  p_stopped_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_run |=> !div_o);

  p_ratio_at_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_ratio != $past(act_ratio)) |-> (!$past(act_run) || $past(cnt) == $past(act_ratio)));

  p_no_zero_stop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[STOP_BIT] |-> (rd_data_o[RATIO_W-1:0] != '0));

  p_unused_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & ~MASK) == 32'h0);

  p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= act_ratio);
endmodule

bind ckdiv_top ckdiv_chk #(.NUM_SRC(NUM_SRC), .SW(SW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .div_o     (div_o),
  .rd_data_o (rd_data_o),
  .act_sel   (act_sel),
  .act_ratio (act_ratio),
  .cnt       (cnt),
  .act_run   (act_run)
);

// File: tb/sim_ckdiv_top.sv
`timescale 1ns/1ps
module sim_ckdiv_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  wr_en = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  src = '0;
  logic [31:0] rd0, rd1, rd2;
  logic        div0, div1, div2;
  int          n_tests = 0;
  int          n_fail = 0;
  int          phase = 0;

  always #4 clk = ~clk;

  ckdiv_top #(.NUM_SRC(8)) u0 (.clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en[0]), .wr_data_i(wr_data),
    .rd_data_o(rd0), .src_i(src), .div_o(div0));
  ckdiv_top #(.NUM_SRC(1)) u1 (.clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en[1]), .wr_data_i(wr_data),
    .rd_data_o(rd1), .src_i(src[0:0]), .div_o(div1));
  ckdiv_top #(.NUM_SRC(4)) u2 (.clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en[2]), .wr_data_i(wr_data),
    .rd_data_o(rd2), .src_i(src[3:0]), .div_o(div2));

  // source k strobes once every k+1 cycles
  always @(negedge clk) begin
    phase <= phase + 1;
    for (int k = 0; k < 8; k++) src[k] <= ((phase + 1) % (k + 1)) == 0;
  end

  localparam int NV = 7;
  localparam logic [31:0] VEC_REG [NV] = '{32'h3, 32'h4, 32'h3F, 32'h1, 32'h1000, 32'h2002, 32'h7001};
  localparam int VEC_HI  [NV] = '{2, 2, 32, 1, 1, 3, 8};
  localparam int VEC_PER [NV] = '{4, 5, 64, 2, 2, 9, 16};

  function automatic logic out_of(input int w);
    return (w == 0) ? div0 : (w == 1) ? div1 : div2;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int w, input logic [31:0] d);
    @(negedge clk);
    wr_en[w] = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_en    = '0;
  endtask

  task automatic measure(input int w, output int hi, output int per);
    int n = 0;
    hi = 0;
    while (out_of(w) == 1'b1 && n < 3000) begin @(negedge clk); n++; end
    while (out_of(w) == 1'b0 && n < 3000) begin @(negedge clk); n++; end
    while (out_of(w) == 1'b1 && n < 3000) begin hi++; @(negedge clk); n++; end
    per = hi;
    while (out_of(w) == 1'b0 && n < 3000) begin per++; @(negedge clk); n++; end
  endtask

  task automatic settle_measure(input int w, input string req, input int ehi, input int eper);
    int hi, per;
    measure(w, hi, per);
    measure(w, hi, per);
    check(req, hi, ehi);
    check(req, per, eper);
  endtask

  // wait for a rising output, write d during the high phase, return total high length
  task automatic write_in_high(input logic [31:0] d, output int hi);
    int n = 0;
    hi = 0;
    while (div0 == 1'b1 && n < 3000) begin @(negedge clk); n++; end
    while (div0 == 1'b0 && n < 3000) begin @(negedge clk); n++; end
    hi = 1;
    wr_en[0] = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_en    = '0;
    while (div0 == 1'b1 && n < 3000) begin hi++; @(negedge clk); n++; end
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int hi;
    int lows;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 reset state
    check("R6", rd0, 32'h13F);
    check("R6", rd1, 32'h13F);
    check("R6", rd2, 32'h13F);
    lows = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); lows += int'(div0); end
    check("R3 stopped after reset", lows, 0);

    // R1 R2 R7 vector walk on the eight-source variant
    for (int v = 0; v < NV; v++) begin
      wr(0, VEC_REG[v]);
      check("R5 readback", rd0, VEC_REG[v]);
      settle_measure(0, "R1/R2/R7 vector", VEC_HI[v], VEC_PER[v]);
    end

    // R8 ratio change mid-pulse keeps full high phase
    wr(0, 32'h3F);
    settle_measure(0, "R1", 32, 64);
    write_in_high(32'h1, hi);
    check("R8 full pulse", hi, 32);
    settle_measure(0, "R8 new ratio", 1, 2);

    // R9 stop during the high phase waits for the period end
    wr(0, 32'h3F);
    settle_measure(0, "R1", 32, 64);
    write_in_high(32'h13F, hi);
    check("R9 stop waits", hi, 32);
    lows = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); lows += int'(div0); end
    check("R3 held low", lows, 0);
    wr(0, 32'h3);
    settle_measure(0, "R3 restart", 2, 4);

    // R4 zero ratio with stop
    wr(0, 32'h100);
    check("R4", rd0, 32'h13F);
    wr(0, 32'h1100);
    check("R4", rd0, 32'h113F);

    // R5 unused bits on each variant
    wr(0, 32'hFFFF_FFFF);
    check("R5 eight", rd0, 32'h713F);
    wr(1, 32'hFFFF_FFFF);
    check("R5 single", rd1, 32'h13F);
    wr(2, 32'hFFFF_FFFF);
    check("R5 four", rd2, 32'h1FF);

    // R7 single-source ignores select bits, four-source uses bits 7:6
    wr(1, 32'h70C3);
    check("R7 single readback", rd1, 32'h3);
    settle_measure(1, "R7 single uses source 0", 2, 4);
    wr(2, 32'h81);
    check("R7 four readback", rd2, 32'h81);
    settle_measure(2, "R7 four source 2", 3, 6);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule